// File: doc/BRIEF.md
# Partitioned Instruction Bus Restorer

This block sits on the fetch path between an instruction memory bus and a processor front end. Some instruction sequences in memory were rewritten offline so that successive words toggle fewer bus lines. The block puts the original 32-bit instructions back together before they reach the processor. It keeps a small table of block start addresses. When a fetch address matches one of them, the block follows a list of per-instruction recipes held in a second table. Each recipe tells it how to undo the rewrite on every field of the next word.

Each word is cut into six 5-bit fields. The cuts follow the usual RISC field boundaries, so every register specifier is a field of its own. Bits 30 and 6 are never rewritten. For each field, a recipe picks one of four reversible operations: keep it, invert it, XOR it with the same field of the previous raw bus word, or XNOR it with that field. The first word of a block crosses the bus untouched. The block drops back to plain forwarding after the last recipe of the block, or when the fetch address breaks the sequence. Both tables are filled through a single write port before the code runs.

Top module: `instr_stream_restorer`

## Requirements
- R1: A synchronous active-high reset clears out_valid and out_word to zero and empties the start-address table, so no fetch matches until a new entry is written.
- R2: out_valid equals the fetch_valid of the previous cycle. In a cycle with no fetch, out_word keeps its previous value.
- R3: While no block is being restored, a fetch whose address matches no valid start entry is forwarded unchanged on the next cycle.
- R4: A fetch that matches a start entry is forwarded unchanged. The fetch at that address plus 4 is restored with the recipe at the entry's stored index, and each further sequential fetch (plus 4 each time) uses the next recipe index.
- R5: The fields are P0=[4:0], P1={10,9,8,7,5}, P2=[15:11], P3=[20:16], P4=[25:21] and P5={31,29,28,27,26}. In a recipe, the code of field Pn sits at bits [2n+1:2n] and the last-word flag sits at bit 12.
- R6: The field codes are 00 keep, 01 invert, 10 XOR with the previous raw word's bits of that field, and 11 XNOR with them.
- R7: Bits 30 and 6 of out_word always equal the same bits of the fetched word.
- R8: The previous raw word is the fetch_word of the most recent accepted fetch, whatever number of idle cycles followed it.
- R9: After a recipe with the last-word flag set is used, the next fetch is forwarded unchanged unless it matches a start entry.
- R10: While a block is being restored, a fetch at any address other than the expected one ends the restore. That fetch and the ones after it are forwarded unchanged until a start entry matches again.
- R11: The write port selects the recipe table when cfg_tt_sel=1, and then stores cfg_wdata[12:0] at cfg_addr. With cfg_tt_sel=0 it fills start slot cfg_addr with the address cfg_wdata[31:0] and the recipe index cfg_wdata[37:32]. A later write to a slot replaces its contents.
- R12: When several valid slots hold the same start address, the lowest-numbered slot wins. A fetch at the expected sequential address continues the current block even if it also matches a start entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_tt_sel | input | 1 | 1 selects the recipe table, 0 selects the start-address table |
| cfg_addr | input | 6 | Slot or recipe index to write |
| cfg_wdata | input | 38 | Write data (start address and index, or recipe) |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_pc | input | 32 | Address of the fetched word |
| fetch_word | input | 32 | Raw word from the instruction bus |
| out_valid | output | 1 | Registered valid for out_word |
| out_word | output | 32 | Restored instruction, one cycle after the fetch |

## Verification
The assertions assume that reset is held with fetch_valid low and that a recipe is written before any block that points at it is entered. They also assume that recipe writes never happen while a block is being restored. The bench keeps to these assumptions: it writes both tables only between fetch runs with fetch_valid low, and it fills the whole recipe table before any random run starts. Each random block ends with a flagged recipe before it reaches a neighbouring block's region, so the predicted recipe stream always refers to written entries.

// File: rtl/rstr_pkg.sv
package rstr_pkg;
  localparam int WORD_W      = 32;
  localparam int NUM_PARTS   = 6;
  localparam int CODE_W      = 2;
  localparam int TT_ENTRY_W  = NUM_PARTS * CODE_W + 1;
  localparam int NO_PART     = 7;

  typedef enum logic [1:0] {
    FN_KEEP = 2'b00,
    FN_INV  = 2'b01,
    FN_XOR  = 2'b10,
    FN_XNOR = 2'b11
  } fn_code_e;

  typedef struct packed {
    logic                          last;
    logic [NUM_PARTS*CODE_W-1:0]   codes;
  } tt_entry_t;

  // Field that owns a given bus bit; NO_PART for the two untouched bits.
  function automatic int bit_owner(input int b);
    if (b == 30 || b == 6) return NO_PART;
    if (b <= 4)            return 0;
    if (b <= 10)           return 1;
    if (b <= 15)           return 2;
    if (b <= 20)           return 3;
    if (b <= 25)           return 4;
    return 5;
  endfunction
endpackage

// File: rtl/rstr_block_table.sv
module rstr_block_table
  import rstr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 6,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_slot,
  input  logic [WORD_W-1:0] wr_pc,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] look_pc,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [WORD_W-1:0] pc_q  [DEPTH];
  logic [IDX_W-1:0]  idx_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  match;

  always_ff @(posedge clk) begin
    if (rst)        vld_q <= '0;
    else if (wr_en) vld_q[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pc_q[wr_slot]  <= wr_pc;
      idx_q[wr_slot] <= wr_idx;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (pc_q[g] == look_pc);
  end

  // Lowest slot wins: scan downward so the last assignment is the lowest hit.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = idx_q[i];
      end
    end
  end
endmodule

// File: rtl/rstr_xform_mem.sv
module rstr_xform_mem
  import rstr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  tt_entry_t     wr_data,
  input  logic [AW-1:0] rd_addr,
  output tt_entry_t     rd_data
);
  tt_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rstr_lane_decode.sv
module rstr_lane_decode
  import rstr_pkg::*;
(
  input  logic                        en,
  input  logic [NUM_PARTS*CODE_W-1:0] codes,
  input  logic [WORD_W-1:0]           enc_word,
  input  logic [WORD_W-1:0]           prev_word,
  output logic [WORD_W-1:0]           plain_word
);
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    localparam int P = bit_owner(g);
    if (P == NO_PART) begin : g_fixed
      assign plain_word[g] = enc_word[g];
    end else begin : g_coded
      fn_code_e fn;
      assign fn = fn_code_e'(codes[P*CODE_W +: CODE_W]);
      always_comb begin
        if (!en) plain_word[g] = enc_word[g];
        else begin
          case (fn)
            FN_KEEP: plain_word[g] = enc_word[g];
            FN_INV:  plain_word[g] = ~enc_word[g];
            FN_XOR:  plain_word[g] = enc_word[g] ^ prev_word[g];
            default: plain_word[g] = ~(enc_word[g] ^ prev_word[g]);
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/instr_stream_restorer.sv
module instr_stream_restorer
  import rstr_pkg::*;
#(
  parameter int BT_DEPTH = 8,
  parameter int TT_DEPTH = 64,
  localparam int BT_AW  = (BT_DEPTH > 1) ? $clog2(BT_DEPTH) : 1,
  localparam int TT_AW  = (TT_DEPTH > 1) ? $clog2(TT_DEPTH) : 1,
  localparam int CFG_AW = (BT_AW > TT_AW) ? BT_AW : TT_AW,
  localparam int CFG_DW = WORD_W + TT_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_tt_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_pc,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic              active_q;
  logic [TT_AW-1:0]  tt_ptr_q;
  logic [WORD_W-1:0] next_pc_q;
  logic [WORD_W-1:0] prev_word_q;

  logic              bt_we, tt_we;
  logic              bt_hit;
  logic [TT_AW-1:0]  bt_idx;
  tt_entry_t         tt_cur;
  logic              seq_hit;
  logic [WORD_W-1:0] restored;

  assign bt_we = cfg_we && !cfg_tt_sel && ((cfg_addr >> BT_AW) == '0);
  assign tt_we = cfg_we &&  cfg_tt_sel && ((cfg_addr >> TT_AW) == '0);

  rstr_block_table #(.DEPTH(BT_DEPTH), .IDX_W(TT_AW)) u_bt (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bt_we),
    .wr_slot (cfg_addr[BT_AW-1:0]),
    .wr_pc   (cfg_wdata[WORD_W-1:0]),
    .wr_idx  (cfg_wdata[WORD_W +: TT_AW]),
    .look_pc (fetch_pc),
    .hit     (bt_hit),
    .hit_idx (bt_idx)
  );

  rstr_xform_mem #(.DEPTH(TT_DEPTH)) u_tt (
    .clk     (clk),
    .wr_en   (tt_we),
    .wr_addr (cfg_addr[TT_AW-1:0]),
    .wr_data (tt_entry_t'(cfg_wdata[TT_ENTRY_W-1:0])),
    .rd_addr (tt_ptr_q),
    .rd_data (tt_cur)
  );

  assign seq_hit = active_q && (fetch_pc == next_pc_q);

  rstr_lane_decode u_dec (
    .en         (seq_hit),
    .codes      (tt_cur.codes),
    .enc_word   (fetch_word),
    .prev_word  (prev_word_q),
    .plain_word (restored)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      active_q    <= 1'b0;
      tt_ptr_q    <= '0;
      next_pc_q   <= '0;
      prev_word_q <= '0;
    end else begin
      out_valid <= fetch_valid;
      if (fetch_valid) begin
        out_word    <= restored;
        prev_word_q <= fetch_word;
        if (seq_hit) begin
          if (tt_cur.last) begin
            active_q <= 1'b0;
          end else begin
            tt_ptr_q  <= tt_ptr_q + 1'b1;
            next_pc_q <= next_pc_q + 32'd4;
          end
        end else if (bt_hit) begin
          active_q  <= 1'b1;
          tt_ptr_q  <= bt_idx;
          next_pc_q <= fetch_pc + 32'd4;
        end else begin
          active_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rstr_checker.sv
module rstr_checker (
  input logic        clk,
  input logic        rst,
  input logic        fetch_valid,
  input logic [31:0] fetch_word,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        active,
  input logic        hit
);
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> out_valid);

  a_r2_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !out_valid);

  a_r2_word_hold: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> $stable(out_word));

  a_r7_fixed_bits: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (out_word[30] == $past(fetch_word[30])) &&
                    (out_word[6]  == $past(fetch_word[6])));

  a_r3_idle_forward: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !active && !hit) |=> (out_word == $past(fetch_word)));

  a_r4_first_word: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !active && hit) |=> (out_word == $past(fetch_word)));
endmodule

bind instr_stream_restorer rstr_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_valid (fetch_valid),
  .fetch_word  (fetch_word),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .active      (active_q),
  .hit         (bt_hit)
);

// File: tb/tb_instr_stream_restorer.sv
`timescale 1ns/1ps
module tb_instr_stream_restorer;
  localparam logic [31:0] MASK = 32'hBFFF_FFBF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_tt_sel = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [37:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] fetch_word = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  instr_stream_restorer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tt_sel(cfg_tt_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .fetch_word(fetch_word),
    .out_valid(out_valid), .out_word(out_word)
  );

  // Reference state
  logic [31:0] m_bt_pc  [8];
  logic [5:0]  m_bt_idx [8];
  bit          m_bt_v   [8];
  logic [12:0] m_tt     [64];
  bit          m_act;
  logic [5:0]  m_ptr;
  logic [31:0] m_exp_pc;
  logic [31:0] m_prev;
  logic [31:0] last_out;
  int          blen [8];

  int pmap [6][5] = '{'{0,1,2,3,4}, '{5,7,8,9,10}, '{11,12,13,14,15},
                      '{16,17,18,19,20}, '{21,22,23,24,25}, '{26,27,28,29,31}};

  function automatic logic [31:0] bdecode(input logic [31:0] y, input logic [31:0] yp,
                                          input logic [12:0] e);
    logic [31:0] r;
    r = y;
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 5; k++) begin
        int b;
        b = pmap[p][k];
        case (e[2*p +: 2])
          2'd0: r[b] = y[b];
          2'd1: r[b] = ~y[b];
          2'd2: r[b] = y[b] ^ yp[b];
          default: r[b] = ~(y[b] ^ yp[b]);
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] model_step(input logic [31:0] pc, input logic [31:0] w);
    logic [31:0] res;
    int hit_slot;
    res = w;
    if (m_act && pc == m_exp_pc) begin
      res = bdecode(w, m_prev, m_tt[m_ptr]);
      if (m_tt[m_ptr][12]) m_act = 1'b0;
      else begin m_ptr = m_ptr + 6'd1; m_exp_pc = m_exp_pc + 32'd4; end
    end else begin
      hit_slot = -1;
      for (int s = 7; s >= 0; s--) if (m_bt_v[s] && m_bt_pc[s] == pc) hit_slot = s;
      if (hit_slot >= 0) begin
        m_act = 1'b1; m_ptr = m_bt_idx[hit_slot]; m_exp_pc = pc + 32'd4;
      end else m_act = 1'b0;
    end
    m_prev = w;
    return res;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] pc, input logic [31:0] w, input string req);
    logic [31:0] e;
    e = model_step(pc, w);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc; fetch_word = w;
    @(posedge clk); #1;
    chk({31'd0, out_valid}, 32'd1, "R2 valid");
    chk(out_word, e, req);
    last_out = out_word;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    fetch_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
    chk({31'd0, out_valid}, 32'd0, "R2 idle valid");
    chk(out_word, last_out, "R2 hold");
  endtask

  task automatic bt_write(input int slot, input logic [31:0] pc, input logic [5:0] idx);
    @(negedge clk);
    fetch_valid = 1'b0;
    cfg_we = 1'b1; cfg_tt_sel = 1'b0; cfg_addr = 6'(slot); cfg_wdata = {idx, pc};
    @(negedge clk);
    cfg_we = 1'b0;
    m_bt_pc[slot] = pc; m_bt_idx[slot] = idx; m_bt_v[slot] = 1'b1;
  endtask

  task automatic tt_write(input int a, input logic [12:0] e);
    @(negedge clk);
    fetch_valid = 1'b0;
    cfg_we = 1'b1; cfg_tt_sel = 1'b1; cfg_addr = 6'(a); cfg_wdata = {25'd0, e};
    @(negedge clk);
    cfg_we = 1'b0;
    m_tt[a] = e;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fetch_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk({31'd0, out_valid}, 32'd0, "R1 valid");
    chk(out_word, 32'd0, "R1 word");
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 8; s++) m_bt_v[s] = 1'b0;
    m_act = 1'b0; m_prev = '0; m_ptr = '0; m_exp_pc = '0; last_out = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w0, w1, w2, w3, w4, w5, w6;
    void'($urandom(32'd24601));
    for (int i = 0; i < 64; i++) m_tt[i] = '0;
    do_reset();

    // R1/R3: empty table forwards everything
    do_fetch(32'h0000_0100, 32'hDEAD_BEEF, "R1 R3 empty table");
    do_fetch(32'h0000_0104, 32'h1357_9BDF, "R3 idle forward");

    // Directed block at 0x100
    tt_write(0, 13'h0555);
    tt_write(1, 13'h0004);
    tt_write(2, 13'h0400);
    tt_write(3, 13'h0AAA);
    tt_write(4, 13'h1FFF);
    bt_write(0, 32'h0000_0100, 6'd0);
    w0 = 32'h1234_5678; w1 = 32'hF0F0_0F0F; w2 = 32'hA5A5_5A5A;
    w3 = 32'h0C3C_F0E1; w4 = 32'h7777_1111; w5 = 32'h9999_6666; w6 = 32'h4242_2424;
    do_fetch(32'h100, w0, "R4 first word");
    chk(last_out, w0, "R4 first unchanged");
    do_fetch(32'h104, w1, "R6 invert");
    chk(last_out, w1 ^ MASK, "R6 R7 invert all");
    do_fetch(32'h108, w2, "R5 P1");
    chk(last_out, w2 ^ 32'h0000_07A0, "R5 P1 position");
    do_fetch(32'h10C, w3, "R5 P5");
    chk(last_out, w3 ^ 32'hBC00_0000, "R5 P5 position");
    do_fetch(32'h110, w4, "R6 xor");
    chk(last_out, w4 ^ (w3 & MASK), "R6 R8 xor prev raw");
    do_fetch(32'h114, w5, "R6 xnor");
    chk(last_out, w5 ^ (~w4 & MASK), "R6 xnor prev raw");
    do_fetch(32'h118, w6, "R9 after end");
    chk(last_out, w6, "R9 forward after end");

    // R10: break sequence
    do_fetch(32'h100, w0, "R10 start");
    do_fetch(32'h104, w1, "R10 one decoded");
    do_fetch(32'h200, w2, "R10 jump");
    chk(last_out, w2, "R10 jump forwarded");
    do_fetch(32'h108, w3, "R10 no resume");
    chk(last_out, w3, "R10 stays forwarding");

    // R8: gap between fetches
    tt_write(8, 13'h1AAA);
    bt_write(1, 32'h0000_0300, 6'd8);
    do_fetch(32'h300, w4, "R8 start");
    idle(3);
    do_fetch(32'h304, w5, "R8 after gap");
    chk(last_out, w5 ^ (w4 & MASK), "R8 prev across gap");

    // R11: rewrite slot
    bt_write(1, 32'h0000_0380, 6'd8);
    do_fetch(32'h300, w1, "R11 old pc");
    do_fetch(32'h304, w2, "R11 old pc next");
    chk(last_out, w2, "R11 old entry gone");
    do_fetch(32'h380, w1, "R11 new pc");
    do_fetch(32'h384, w2, "R11 new pc next");
    chk(last_out, w2 ^ (w1 & MASK), "R11 new entry used");

    // R12: duplicate start, lowest slot wins
    tt_write(16, 13'h1555);
    tt_write(24, 13'h1000);
    bt_write(3, 32'h0000_0500, 6'd24);
    bt_write(2, 32'h0000_0500, 6'd16);
    do_fetch(32'h500, w0, "R12 dup start");
    do_fetch(32'h504, w3, "R12 dup next");
    chk(last_out, w3 ^ MASK, "R12 lowest slot");
    idle(1);

    // Random tables and runs
    for (int i = 0; i < 64; i++) tt_write(i, {1'b0, 12'($urandom)});
    for (int b = 0; b < 8; b++) begin
      blen[b] = 2 + int'($urandom % 7);
      tt_write(b*8 + blen[b] - 2, {1'b1, m_tt[b*8 + blen[b] - 2][11:0]});
      bt_write(b, 32'h0040_0000 + b*32'h400 + ($urandom % 64) * 4, 6'(b*8));
    end
    for (int s = 0; s < 400; s++) begin
      int b, n;
      logic [31:0] pc;
      b = int'($urandom % 8);
      n = int'($urandom % (blen[b] + 2));
      pc = m_bt_pc[b];
      do_fetch(pc, $urandom, "R4 random start");
      for (int k = 0; k < n; k++) begin
        int r;
        r = int'($urandom % 16);
        if (r == 0) pc = 32'h0080_0000 + ($urandom % 256) * 4;
        else pc = pc + 32'd4;
        if (r == 1) idle(1 + int'($urandom % 3));
        do_fetch(pc, $urandom, "R5 R6 R9 R10 random");
      end
      if ($urandom % 4 == 0) idle(1);
    end

    // R1: reset mid-run empties start table
    do_reset();
    do_fetch(m_bt_pc[0] == 0 ? 32'h4 : 32'h0040_0000, 32'hCAFE_F00D, "R1 no match");
    do_fetch(32'h0040_0000 + 32'h400, 32'h0BAD_F00D, "R1 slot cleared");
    do_fetch(32'h0040_0004 + 32'h400, 32'h5555_AAAA, "R1 slot cleared next");
    chk(last_out, 32'h5555_AAAA, "R1 forwarded after reset");
    idle(1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule